// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the bit-level core of an SPI master. Words queue in a transmit FIFO, are serialised most significant bit first on the data-out line, and the bits captured from the data-in line are assembled into words and queued in a receive FIFO. A transfer is started with a word count. The clock idle level and the capture edge are chosen by two separate control bits, an idle-high bit and a sample-first bit, which together cover the four usual clock modes. The word length is N+1 bits, where N comes from a length field, so the same engine serves 8-bit commands and wider words.

Four chip-select lines are driven. A select field picks the line in use. Further control bits invert the active level of the picked line, force it asserted with no transfer running, or keep it asserted between the words of a transfer. A loopback bit routes the engine's own data-out into its receiver. An output-enable scheme leaves data-out and the chip selects undriven while the engine is idle, unless always-drive is set. Two sticky flags report a clock underrun and a clock overrun. An underrun is a word that cannot be sent because the transmit queue is empty. An overrun is a word that is lost because the receive queue is full. Register decoding sits outside this block, which sees only decoded control inputs.

Top module: `spi_word_shifter`

## Requirements
- R1: The serial clock rests at the level of `cfg_idle_high`. With `cfg_input_first` set, data-in is captured on the first edge of each bit and data-out changes on the second edge. With it clear, data-out changes on the first edge and data-in is captured on the second.
- R2: A word is `cfg_len`+1 bits long and is shifted most significant bit first in both directions. Each word produces exactly 2*(`cfg_len`+1) clock edges. A received word arrives right-aligned with its upper bits zero.
- R3: With `cfg_loopback` set, the receiver captures the engine's own data-out and ignores `spi_miso`.
- R4: Only the line whose index equals `cfg_cs_sel` is ever asserted. All other lines stay high.
- R5: With `cfg_cs_active_high` clear, the selected line is low while asserted and high otherwise. With it set, the selected line is high while asserted and low otherwise.
- R6: With `cfg_force_cs` set, the selected line is asserted and `spi_cs_oe` is high even when no transfer runs.
- R7: With `cfg_hold_cs` set, the chip select stays asserted from the first word of a transfer to the last. With it clear, the line is released between words, so an n-word transfer gives n assertions.
- R8: While a transfer runs, `spi_mosi_oe` and `spi_cs_oe` are high. While idle they follow `cfg_drive_always` (0 means the lines float).
- R9: If the transmit queue is enabled and empty when a word must start, the clock stops, `err_clk_under` is set, and the word is sent once data arrives. Both error flags clear when a transfer is accepted.
- R10: A word that completes while the receive FIFO is full is dropped and `err_clk_over` is set. Earlier words are kept in order.
- R11: With `cfg_tx_en` clear, all-zero words are sent, the clock still runs and the transmit FIFO is left alone. With `cfg_rx_en` clear, nothing is written to the receive FIFO.
- R12: Consecutive clock edges inside a word are CLK_DIV/2 system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 5 | Word length minus one |
| cfg_idle_high | input | 1 | Serial clock idles high |
| cfg_input_first | input | 1 | Capture on the first edge of each bit |
| cfg_loopback | input | 1 | Feed data-out back to the receiver |
| cfg_cs_sel | input | 2 | Index of the chip select in use |
| cfg_cs_active_high | input | 1 | Invert the active level of the selected line |
| cfg_force_cs | input | 1 | Hold the selected line asserted |
| cfg_hold_cs | input | 1 | Keep chip select asserted between words |
| cfg_drive_always | input | 1 | Drive outputs while idle |
| cfg_tx_en | input | 1 | Take words from the transmit FIFO |
| cfg_rx_en | input | 1 | Store received words |
| xfer_start | input | 1 | Start pulse, accepted when idle with a non-zero count |
| xfer_words | input | 16 | Number of words in the transfer |
| tx_push | input | 1 | Write into the transmit FIFO |
| tx_data | input | 32 | Transmit word, right-aligned |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | 32 | Head of the receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Chip-select lines |
| spi_cs_oe | output | 1 | Output enable for chip selects |
| busy | output | 1 | A transfer is in progress |
| err_clk_under | output | 1 | Sticky underrun flag |
| err_clk_over | output | 1 | Sticky overrun flag |

## Verification
A wrong bit or edge counter shows up within one word. The slave model sees the wrong number of clock edges, and the captured and returned words are shifted or cut short. A phase error swaps the capture and launch edges, which corrupts the received data in the first word under that mode. A stuck sequencer shows as a clock that stops or a `busy` that never falls. Errors in the chip-select path appear one cycle after the sequencer changes state, so the line levels are sampled in the middle of each transfer and again after it.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } eng_state_t;
endpackage

// File: rtl/spi_shift_fifo.sv
module spi_shift_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [AW:0]       count;
  logic              do_push, do_pop;

  assign full     = (count == (AW+1)'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  assert_full_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(wptr)));

  assert_push_fills_R10: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop) |=> !empty);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CLK_DIV = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(DATA_W)-1:0] cfg_len,
  input  logic                      cfg_idle_high,
  input  logic                      cfg_input_first,
  input  logic                      cfg_loopback,
  input  logic                      cfg_hold_cs,
  input  logic                      cfg_drive_always,
  input  logic                      cfg_tx_en,
  input  logic                      cfg_rx_en,
  input  logic                      start,
  input  logic [CNT_W-1:0]          words,
  input  logic                      tx_empty,
  input  logic [DATA_W-1:0]         tx_word,
  output logic                      tx_pop,
  input  logic                      rx_full,
  output logic                      rx_push,
  output logic [DATA_W-1:0]         rx_word,
  input  logic                      miso,
  output logic                      sck,
  output logic                      mosi,
  output logic                      mosi_oe,
  output logic                      cs_req,
  output logic                      busy,
  output logic                      err_under,
  output logic                      err_over
);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int HALF  = CLK_DIV / 2;
  localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int E_W   = LEN_W + 1;

  eng_state_t        state;
  logic [HC_W-1:0]   hcnt;
  logic [E_W-1:0]    ecnt;
  logic [CNT_W-1:0]  left;
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_next;
  logic              mid, sck_q, oe_q, under_q, over_q;
  logic              half_done, is_sample, is_drive, in_bit, edge_now, word_done;
  logic [E_W-1:0]    last_e;

  assign half_done = (hcnt == HC_W'(HALF - 1));
  assign last_e    = {cfg_len, 1'b1};
  assign is_sample = (ecnt[0] == ~cfg_input_first);
  assign is_drive  = !is_sample && (ecnt != '0) && (ecnt != last_e);
  assign in_bit    = cfg_loopback ? tx_sr[cfg_len] : miso;
  assign edge_now  = (state == ST_SHIFT) && half_done;
  assign word_done = edge_now && (ecnt == last_e);

  always_comb begin
    rx_next = rx_sr;
    if (is_sample) rx_next = {rx_sr[DATA_W-2:0], in_bit};
  end

  assign tx_pop    = (state == ST_LOAD) && cfg_tx_en && !tx_empty;
  assign rx_push   = word_done && cfg_rx_en && !rx_full;
  assign rx_word   = rx_next;
  assign sck       = sck_q;
  assign mosi      = tx_sr[cfg_len];
  assign mosi_oe   = oe_q;
  assign busy      = (state != ST_IDLE);
  assign err_under = under_q;
  assign err_over  = over_q;
  assign cs_req    = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_TAIL) ||
                     (cfg_hold_cs && mid && ((state == ST_GAP) || (state == ST_LOAD)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      hcnt    <= '0;
      ecnt    <= '0;
      left    <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      mid     <= 1'b0;
      sck_q   <= 1'b0;
      oe_q    <= 1'b0;
      under_q <= 1'b0;
      over_q  <= 1'b0;
    end else begin
      oe_q <= cfg_drive_always || (state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          sck_q <= cfg_idle_high;
          mid   <= 1'b0;
          hcnt  <= '0;
          if (start && (words != '0)) begin
            left    <= words;
            under_q <= 1'b0;
            over_q  <= 1'b0;
            state   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (!cfg_tx_en) begin
            tx_sr <= '0;
            rx_sr <= '0;
            hcnt  <= '0;
            state <= ST_SETUP;
          end else if (!tx_empty) begin
            tx_sr <= tx_word;
            rx_sr <= '0;
            hcnt  <= '0;
            state <= ST_SETUP;
          end else begin
            under_q <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (half_done) begin
            hcnt  <= '0;
            ecnt  <= '0;
            state <= ST_SHIFT;
          end else begin
            hcnt <= hcnt + HC_W'(1);
          end
        end
        ST_SHIFT: begin
          if (half_done) begin
            hcnt  <= '0;
            sck_q <= ~sck_q;
            rx_sr <= rx_next;
            if (is_drive) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            if (ecnt == last_e) begin
              left  <= left - CNT_W'(1);
              state <= ST_TAIL;
              if (cfg_rx_en && rx_full) over_q <= 1'b1;
            end else begin
              ecnt <= ecnt + E_W'(1);
            end
          end else begin
            hcnt <= hcnt + HC_W'(1);
          end
        end
        ST_TAIL: begin
          if (half_done) begin
            hcnt <= '0;
            if (left == '0) begin
              state <= ST_IDLE;
            end else begin
              mid   <= 1'b1;
              state <= ST_GAP;
            end
          end else begin
            hcnt <= hcnt + HC_W'(1);
          end
        end
        ST_GAP: begin
          if (half_done) begin
            hcnt  <= '0;
            state <= ST_LOAD;
          end else begin
            hcnt <= hcnt + HC_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_clock_rests_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL) |-> (sck_q == cfg_idle_high));

  assert_edge_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> (ecnt <= last_e));

  assert_stall_no_clock_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |=> $stable(sck_q));

  assert_under_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_LOAD) && cfg_tx_en && tx_empty) |=> err_under);

  assert_over_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (word_done && cfg_rx_en && rx_full) |=> err_over);

  assert_oe_active_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> mosi_oe);
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_req,
  input  logic                      cfg_force,
  input  logic [$clog2(NUM_CS)-1:0] cfg_sel,
  input  logic                      cfg_pol,
  input  logic                      cfg_drive_always,
  input  logic                      busy,
  output logic [NUM_CS-1:0]         cs_n,
  output logic                      cs_oe
);
  localparam int SEL_W = $clog2(NUM_CS);

  logic assert_now;
  logic oe_q;

  assign assert_now = cs_req || cfg_force;
  assign cs_oe      = oe_q;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= cfg_drive_always || busy || cfg_force;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic line_q;
    logic picked;
    assign picked = (cfg_sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (rst)                  line_q <= 1'b1;
      else if (picked && cfg_pol) line_q <= assert_now;
      else                      line_q <= !(picked && assert_now);
    end
    assign cs_n[i] = line_q;
  end

  assert_single_line_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pol && $past(!cfg_pol)) |-> $onehot0(~cs_n));

  assert_forced_line_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_force) && $stable(cfg_sel) && !cfg_pol && $past(!cfg_pol)) |-> !cs_n[cfg_sel]);
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 4,
  parameter int CLK_DIV  = 4,
  parameter int CNT_W    = 16,
  parameter int NUM_CS   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(DATA_W)-1:0] cfg_len,
  input  logic                      cfg_idle_high,
  input  logic                      cfg_input_first,
  input  logic                      cfg_loopback,
  input  logic [$clog2(NUM_CS)-1:0] cfg_cs_sel,
  input  logic                      cfg_cs_active_high,
  input  logic                      cfg_force_cs,
  input  logic                      cfg_hold_cs,
  input  logic                      cfg_drive_always,
  input  logic                      cfg_tx_en,
  input  logic                      cfg_rx_en,
  input  logic                      xfer_start,
  input  logic [CNT_W-1:0]          xfer_words,
  input  logic                      tx_push,
  input  logic [DATA_W-1:0]         tx_data,
  output logic                      tx_full,
  input  logic                      rx_pop,
  output logic [DATA_W-1:0]         rx_data,
  output logic                      rx_valid,
  output logic                      spi_sck,
  output logic                      spi_mosi,
  output logic                      spi_mosi_oe,
  input  logic                      spi_miso,
  output logic [NUM_CS-1:0]         spi_cs_n,
  output logic                      spi_cs_oe,
  output logic                      busy,
  output logic                      err_clk_under,
  output logic                      err_clk_over
);
  logic              tx_empty, tx_pop, rx_full, rx_push, rx_empty, cs_req;
  logic [DATA_W-1:0] tx_word, rx_word;

  assign rx_valid = !rx_empty;

  spi_shift_fifo #(.DATA_W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk(clk), .rst(rst), .push(tx_push), .push_data(tx_data), .full(tx_full),
    .pop(tx_pop), .pop_data(tx_word), .empty(tx_empty)
  );

  spi_shift_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk(clk), .rst(rst), .push(rx_push), .push_data(rx_word), .full(rx_full),
    .pop(rx_pop), .pop_data(rx_data), .empty(rx_empty)
  );

  spi_shift_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CLK_DIV(CLK_DIV)) u_engine (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_idle_high(cfg_idle_high),
    .cfg_input_first(cfg_input_first), .cfg_loopback(cfg_loopback),
    .cfg_hold_cs(cfg_hold_cs), .cfg_drive_always(cfg_drive_always),
    .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .start(xfer_start), .words(xfer_words),
    .tx_empty(tx_empty), .tx_word(tx_word), .tx_pop(tx_pop), .rx_full(rx_full),
    .rx_push(rx_push), .rx_word(rx_word), .miso(spi_miso), .sck(spi_sck),
    .mosi(spi_mosi), .mosi_oe(spi_mosi_oe), .cs_req(cs_req), .busy(busy),
    .err_under(err_clk_under), .err_over(err_clk_over)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst(rst), .cs_req(cs_req), .cfg_force(cfg_force_cs), .cfg_sel(cfg_cs_sel),
    .cfg_pol(cfg_cs_active_high), .cfg_drive_always(cfg_drive_always), .busy(busy),
    .cs_n(spi_cs_n), .cs_oe(spi_cs_oe)
  );
endmodule

// File: tb/spi_word_shifter_test.sv
module spi_word_shifter_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5ns clk = ~clk;

  logic [4:0]  cfg_len = 5'd7;
  logic        cfg_idle_high = 0, cfg_input_first = 1, cfg_loopback = 0;
  logic [1:0]  cfg_cs_sel = 0;
  logic        cfg_cs_active_high = 0, cfg_force_cs = 0, cfg_hold_cs = 1;
  logic        cfg_drive_always = 0, cfg_tx_en = 1, cfg_rx_en = 1;
  logic        xfer_start = 0;
  logic [15:0] xfer_words = 0;
  logic        tx_push = 0, rx_pop = 0;
  logic [31:0] tx_data = 0;
  logic        tx_full, rx_valid, spi_sck, spi_mosi, spi_mosi_oe, spi_miso, spi_cs_oe;
  logic        busy, err_clk_under, err_clk_over;
  logic [31:0] rx_data;
  logic [3:0]  spi_cs_n;

  spi_word_shifter uut (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_idle_high(cfg_idle_high),
    .cfg_input_first(cfg_input_first), .cfg_loopback(cfg_loopback), .cfg_cs_sel(cfg_cs_sel),
    .cfg_cs_active_high(cfg_cs_active_high), .cfg_force_cs(cfg_force_cs),
    .cfg_hold_cs(cfg_hold_cs), .cfg_drive_always(cfg_drive_always), .cfg_tx_en(cfg_tx_en),
    .cfg_rx_en(cfg_rx_en), .xfer_start(xfer_start), .xfer_words(xfer_words),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_valid(rx_valid), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
    .spi_cs_oe(spi_cs_oe), .busy(busy), .err_clk_under(err_clk_under),
    .err_clk_over(err_clk_over)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model
  logic [31:0] resp [8];
  logic [31:0] cap [8];
  int sidx = 0, sck_edges = 0, cs_falls = 0, cyc = 0, last_edge_cyc = 0, first_gap = 0;
  logic mon_en = 0;
  logic cs_prev = 1;

  always @(negedge clk) begin
    cyc++;
    if (mon_en && cs_prev && !spi_cs_n[cfg_cs_sel]) cs_falls++;
    cs_prev = spi_cs_n[cfg_cs_sel];
  end

  always_comb begin
    int w, wi, bi;
    w  = int'(cfg_len) + 1;
    wi = sidx / w;
    bi = w - 1 - (sidx % w);
    spi_miso = (wi < 8) ? resp[wi][bi] : 1'b0;
  end

  always @(spi_sck) begin
    int w, wi, bi;
    if (mon_en) begin
      sck_edges++;
      if (sck_edges == 2) first_gap = cyc - last_edge_cyc;
      last_edge_cyc = cyc;
      if ((spi_sck != cfg_idle_high) == cfg_input_first) begin
        w  = int'(cfg_len) + 1;
        wi = sidx / w;
        bi = w - 1 - (sidx % w);
        if (wi < 8) cap[wi][bi] = spi_mosi;
        sidx++;
      end
    end
  end

  function automatic logic [31:0] msk(input logic [31:0] v);
    int w;
    w = int'(cfg_len) + 1;
    return (w == 32) ? v : (v & ((32'd1 << w) - 32'd1));
  endfunction

  task automatic clear_slave();
    sidx = 0; sck_edges = 0; cs_falls = 0; first_gap = 0;
    for (int i = 0; i < 8; i++) cap[i] = '0;
  endtask

  task automatic push_word(input logic [31:0] v);
    @(negedge clk); tx_push = 1; tx_data = v;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic start_xfer(input int n);
    @(negedge clk); xfer_words = 16'(n); xfer_start = 1; mon_en = 1;
    @(negedge clk); xfer_start = 0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    mon_en = 0;
  endtask

  task automatic pop_word(output logic [31:0] v, output logic ok);
    @(negedge clk);
    ok = rx_valid; v = rx_data;
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic drain();
    while (rx_valid) begin
      @(negedge clk); rx_pop = 1;
      @(negedge clk); rx_pop = 0;
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R8 reset busy", busy, 0);
    chk("R4 reset cs lines", spi_cs_n, 4'hF);
    chk("R8 reset mosi_oe", spi_mosi_oe, 0);
    chk("R8 reset cs_oe", spi_cs_oe, 0);
    chk("R9 reset under", err_clk_under, 0);
    chk("R10 reset over", err_clk_over, 0);
    chk("R1 reset sck", spi_sck, 0);
  endtask

  task automatic test_modes();
    logic [31:0] v; logic ok;
    for (int m = 0; m < 4; m++) begin
      cfg_len = 7; cfg_hold_cs = 1;
      cfg_idle_high = m[1]; cfg_input_first = ~m[0];
      settle(); clear_slave();
      chk("R1 idle level", spi_sck, 32'(m[1]));
      resp[0] = 32'hA5 ^ 32'(m); resp[1] = 32'h3C + 32'(m);
      push_word(32'h96 + 32'(m)); push_word(32'h5A ^ 32'(m));
      start_xfer(2); wait_done();
      chk("R1 mode tx word0", cap[0], 32'h96 + 32'(m));
      chk("R1 mode tx word1", cap[1], 32'h5A ^ 32'(m));
      pop_word(v, ok); chk("R1 mode rx word0", v, 32'hA5 ^ 32'(m));
      pop_word(v, ok); chk("R1 mode rx word1", v, 32'h3C + 32'(m));
      chk("R2 edge count", sck_edges, 32);
      chk("R12 half period", first_gap, DIV / 2);
      chk("R1 rest level", spi_sck, 32'(m[1]));
    end
    cfg_idle_high = 0; cfg_input_first = 1;
  endtask

  task automatic test_length();
    logic [31:0] v; logic ok;
    cfg_len = 4; settle(); clear_slave();
    resp[0] = 32'h0B;
    push_word(32'h1F3); start_xfer(1); wait_done();
    chk("R2 5-bit tx", cap[0], 32'h13);
    pop_word(v, ok); chk("R2 5-bit rx", v, 32'h0B);
    chk("R2 5-bit edges", sck_edges, 10);
    cfg_len = 12; settle(); clear_slave();
    resp[0] = 32'h1234;
    push_word(32'hABCD); start_xfer(1); wait_done();
    chk("R2 13-bit tx", cap[0], msk(32'hABCD));
    pop_word(v, ok); chk("R2 13-bit rx", v, msk(32'h1234));
    chk("R2 13-bit edges", sck_edges, 26);
    cfg_len = 7;
  endtask

  task automatic test_loopback();
    logic [31:0] v; logic ok;
    cfg_loopback = 1; settle(); clear_slave();
    resp[0] = 32'hFF;
    push_word(32'h4D); start_xfer(1); wait_done();
    pop_word(v, ok); chk("R3 loopback rx", v, 32'h4D);
    cfg_loopback = 0;
  endtask

  task automatic test_select_and_polarity();
    cfg_cs_sel = 2; cfg_hold_cs = 0; settle(); clear_slave();
    push_word(32'h01); start_xfer(1);
    repeat (6) @(negedge clk);
    chk("R4 line 2 asserted", spi_cs_n, 4'b1011);
    wait_done(); drain();
    chk("R4 lines released", spi_cs_n, 4'hF);
    cfg_cs_sel = 1; cfg_cs_active_high = 1; settle(); clear_slave();
    chk("R5 inverted idle", spi_cs_n, 4'b1101);
    push_word(32'h02); start_xfer(1);
    repeat (6) @(negedge clk);
    chk("R5 inverted active", spi_cs_n, 4'b1111);
    wait_done(); drain();
    chk("R5 inverted after", spi_cs_n, 4'b1101);
    cfg_cs_active_high = 0; cfg_cs_sel = 0; cfg_hold_cs = 1; settle();
  endtask

  task automatic test_force();
    cfg_force_cs = 1; cfg_cs_sel = 3; settle();
    chk("R6 forced line", spi_cs_n, 4'b0111);
    chk("R6 forced oe", spi_cs_oe, 1);
    cfg_force_cs = 0; settle();
    chk("R6 release line", spi_cs_n, 4'hF);
    chk("R6 release oe", spi_cs_oe, 0);
    cfg_cs_sel = 0; settle();
  endtask

  task automatic test_hold();
    cfg_hold_cs = 0; settle(); clear_slave();
    push_word(32'h11); push_word(32'h22); start_xfer(2); wait_done(); drain();
    chk("R7 released between words", cs_falls, 2);
    cfg_hold_cs = 1; settle(); clear_slave();
    push_word(32'h33); push_word(32'h44); start_xfer(2); wait_done(); drain();
    chk("R7 held across words", cs_falls, 1);
  endtask

  task automatic test_tristate();
    cfg_drive_always = 0; settle(); clear_slave();
    chk("R8 idle float mosi", spi_mosi_oe, 0);
    chk("R8 idle float cs", spi_cs_oe, 0);
    push_word(32'h55); start_xfer(1);
    repeat (6) @(negedge clk);
    chk("R8 active mosi_oe", spi_mosi_oe, 1);
    chk("R8 active cs_oe", spi_cs_oe, 1);
    wait_done(); drain();
    cfg_drive_always = 1; settle();
    chk("R8 driven idle mosi", spi_mosi_oe, 1);
    chk("R8 driven idle cs", spi_cs_oe, 1);
    cfg_drive_always = 0; settle();
  endtask

  task automatic test_underrun();
    settle(); clear_slave();
    start_xfer(1);
    repeat (20) @(negedge clk);
    chk("R9 under flag", err_clk_under, 1);
    chk("R9 stalled busy", busy, 1);
    chk("R9 no clock while stalled", sck_edges, 0);
    push_word(32'h77); wait_done(); drain();
    chk("R9 word after stall", cap[0], 32'h77);
    chk("R9 flag sticky", err_clk_under, 1);
    clear_slave();
    push_word(32'h78); start_xfer(1);
    chk("R9 flag cleared on start", err_clk_under, 0);
    wait_done(); drain();
  endtask

  task automatic test_overrun();
    logic [31:0] v; logic ok;
    drain(); settle(); clear_slave();
    for (int i = 0; i < 5; i++) begin
      resp[i] = 32'h10 + 32'(i);
      push_word(32'h80 + 32'(i));
    end
    start_xfer(5); wait_done();
    chk("R10 over flag", err_clk_over, 1);
    for (int i = 0; i < 4; i++) begin
      pop_word(v, ok);
      chk("R10 kept word", v, 32'h10 + 32'(i));
    end
    chk("R10 fifth dropped", rx_valid, 0);
  endtask

  task automatic test_disable();
    logic [31:0] v; logic ok;
    cfg_tx_en = 0; settle(); clear_slave();
    resp[0] = 32'hC3; resp[1] = 32'h5E;
    start_xfer(2); wait_done();
    chk("R11 zero word0", cap[0], 0);
    chk("R11 zero word1", cap[1], 0);
    chk("R11 clocks run", sck_edges, 32);
    pop_word(v, ok); chk("R11 rx-only word0", v, 32'hC3);
    pop_word(v, ok); chk("R11 rx-only word1", v, 32'h5E);
    cfg_tx_en = 1; cfg_rx_en = 0; settle(); clear_slave();
    push_word(32'h11); start_xfer(1); wait_done();
    chk("R11 tx-only sent", cap[0], 32'h11);
    chk("R11 nothing stored", rx_valid, 0);
    cfg_rx_en = 1; settle();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    test_modes();
    test_length();
    test_loopback();
    test_select_and_polarity();
    test_force();
    test_hold();
    test_tristate();
    test_underrun();
    test_overrun();
    test_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule